// File: doc/BRIEF.md
# Receive Link Synchronisation Tracker

This block watches the character stream that leaves an 8B/10B decoder and decides whether the receive link is still synchronised. In every cycle it receives one flag per lane for a symbol outside the code table, one flag per lane for a symbol with a running-disparity violation, and one flag that says a comma was received and aligned. Any lane with either flag set holds an invalid character. The invalid characters feed a leaky error counter. A single invalid character moves the tracker from the acquired state into a short resync window. When the count builds up to a threshold, the tracker declares the link lost and asks the aligner to search for a comma again.

The error counter advances by a parameterised weight for every invalid character. It leaks away by one after each run of clean cycles as long as the threshold. Sparse errors therefore never add up to a loss, while dense bursts do. The tracker works only while the decode path is in use and the receive clock is locked. A tracking-enable input states that condition, and while it is low the tracker rests in the acquired state with no error history.

Top module: `rx_sync_tracker`

## Requirements
- R1: `sync_status` encodes the state as 2'b00 acquired, 2'b01 resync and 2'b10 lost. `realign_req` is high exactly when `sync_status` is 2'b10.
- R2: A low `rst_n` forces the lost state at once and clears the error history. A high `rx_reset` at a clock edge does the same at that edge and takes priority over every other input.
- R3: Lane i holds an invalid character in a cycle when `sym_bad_table[i]` or `sym_bad_disp[i]` is high. A lane with both flags high counts once. Any invalid character in the acquired state leaves that state at the next edge.
- R4: The error count grows by INCR (default 1) for each invalid lane in a cycle, so two invalid lanes in one cycle add 2*INCR.
- R5: When the grown count reaches THRESH (default 4) in the acquired or resync state, the next state is lost and the count is cleared.
- R6: The resync state lasts exactly WAIT_CYCLES (default 4) consecutive clean cycles and then returns to acquired. An invalid character that does not trip R5 restarts the window.
- R7: In the acquired and resync states, each run of THRESH consecutive clean cycles lowers the count by one, never below zero. An invalid character restarts the run.
- R8: In the lost state, invalid characters have no effect. The tracker moves to acquired at the next edge only in a cycle with `comma_ok` high and no invalid character.
- R9: While `track_en` is low (and `rx_reset` is low), the next state is acquired, the count is cleared, and the error inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive user clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_reset | input | 1 | Synchronous receive reset, active high |
| track_en | input | 1 | High while the decode path is in use and the clock is locked |
| sym_bad_table | input | LANES | Per-lane flag for a symbol outside the code table |
| sym_bad_disp | input | LANES | Per-lane flag for a running-disparity error |
| comma_ok | input | 1 | A valid comma was received and aligned this cycle |
| sync_status | output | 2 | Synchronisation state code |
| realign_req | output | 1 | Request to the aligner to search for a comma |

## Verification
On every cycle, the in-line properties check several things:
- a receive reset always lands in the lost state;
- an error in the acquired state always leaves it;
- the lost state holds until a clean comma arrives;
- a tripped threshold always produces the lost state;
- the resync wait counter and the error count stay inside their ranges;
- each leak step lowers the count by exactly one.

Only the bench's scenarios can show the exact state codes and the cycle on which each transition falls. These scenarios include errors spaced four cycles apart that reach the threshold, errors spaced five cycles apart that never do, the leak rescuing a count of three, two-lane weighting, and the restart of the resync window.

// File: rtl/rxsync_pkg.sv
package rxsync_pkg;

  typedef enum logic [1:0] {
    SY_ACQ    = 2'b00,
    SY_RESYNC = 2'b01,
    SY_LOST   = 2'b10
  } sync_state_e;

  // count after a cycle with nbad invalid characters, each weighted by step
  function automatic int unsigned weigh_errors(int unsigned cur, int unsigned nbad,
                                               int unsigned step);
    return cur + nbad * step;
  endfunction

  // one leak step, floored at zero
  function automatic int unsigned leak_one(int unsigned cur);
    return (cur == 0) ? 0 : cur - 1;
  endfunction

endpackage

// File: rtl/rxsync_errsum.sv
module rxsync_errsum #(
  parameter int LANES = 2,
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0] bad_table,
  input  logic [LANES-1:0] bad_disp,
  output logic [NW-1:0]    nbad,
  output logic             any_bad
);

  logic [LANES-1:0] lane_bad;

  // R3: a lane is invalid on either flag; both flags count once
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_bad[g] = bad_table[g] | bad_disp[g];
    end
  endgenerate

  always_comb begin
    nbad = '0;
    for (int i = 0; i < LANES; i++) begin
      nbad = nbad + NW'(lane_bad[i]);
    end
  end

  assign any_bad = |lane_bad;

endmodule

// File: rtl/rxsync_leaky.sv
module rxsync_leaky
  import rxsync_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int INCR   = 1,
  parameter int THRESH = 4,
  localparam int NW = $clog2(LANES + 1),
  localparam int CW = $clog2(THRESH + 1),
  localparam int RW = $clog2(THRESH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          count_en,
  input  logic [NW-1:0] nbad,
  output logic          trip,
  output logic          decay_evt
);

  logic [CW-1:0] cnt_q;
  logic [RW-1:0] run_q;
  int unsigned   sum_w;
  int unsigned   leak_w;

  always_comb begin
    sum_w  = weigh_errors(32'(cnt_q), 32'(nbad), INCR);
    leak_w = leak_one(32'(cnt_q));
  end

  assign trip      = count_en && (nbad != '0) && (sum_w >= THRESH);
  assign decay_evt = count_en && (nbad == '0) && (run_q == RW'(THRESH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= '0;
    end else if (clear || !count_en || trip) begin
      cnt_q <= '0;
      run_q <= '0;
    end else if (nbad != '0) begin
      cnt_q <= CW'(sum_w);
      run_q <= '0;
    end else if (decay_evt) begin
      cnt_q <= CW'(leak_w);
      run_q <= '0;
    end else begin
      run_q <= run_q + RW'(1);
    end
  end

  AST_CNT_BELOW_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(THRESH)); // R5

  AST_DECAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (decay_evt && !clear && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CW'(1)); // R7

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt_q == '0); // R2

endmodule

// File: rtl/rxsync_fsm.sv
module rxsync_fsm
  import rxsync_pkg::*;
#(
  parameter int WAIT_CYCLES = 4,
  localparam int WW = $clog2(WAIT_CYCLES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_reset,
  input  logic        en,
  input  logic        any_bad,
  input  logic        trip,
  input  logic        comma_ok,
  output sync_state_e state_q
);

  sync_state_e state_d;
  logic [WW-1:0] wait_q, wait_d;

  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    if (rx_reset) begin
      state_d = SY_LOST;
      wait_d  = '0;
    end else if (!en) begin
      state_d = SY_ACQ;
      wait_d  = '0;
    end else begin
      unique case (state_q)
        SY_ACQ: begin
          wait_d = '0;
          if (any_bad) state_d = trip ? SY_LOST : SY_RESYNC;
        end
        SY_RESYNC: begin
          if (trip) begin
            state_d = SY_LOST;
            wait_d  = '0;
          end else if (any_bad) begin
            wait_d = '0;
          end else if (wait_q == WW'(WAIT_CYCLES - 1)) begin
            state_d = SY_ACQ;
            wait_d  = '0;
          end else begin
            wait_d = wait_q + WW'(1);
          end
        end
        SY_LOST: begin
          wait_d = '0;
          if (comma_ok && !any_bad) state_d = SY_ACQ;
        end
        default: begin
          state_d = SY_LOST;
          wait_d  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SY_LOST;
      wait_q  <= '0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
    end
  end

  AST_RESET_TO_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> state_q == SY_LOST); // R2

  AST_ACQ_LEAVES_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SY_ACQ && any_bad && en && !rx_reset) |=> state_q != SY_ACQ); // R3

  AST_TRIP_TO_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && en && !rx_reset) |=> state_q == SY_LOST); // R5

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q < WW'(WAIT_CYCLES)); // R6

  AST_LOST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SY_LOST && en && !rx_reset && !(comma_ok && !any_bad))
      |=> state_q == SY_LOST); // R8

  AST_DISABLE_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !rx_reset) |=> state_q == SY_ACQ); // R9

endmodule

// File: rtl/rx_sync_tracker.sv
module rx_sync_tracker
  import rxsync_pkg::*;
#(
  parameter int LANES       = 2,
  parameter int INCR        = 1,
  parameter int THRESH      = 4,
  parameter int WAIT_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_reset,
  input  logic             track_en,
  input  logic [LANES-1:0] sym_bad_table,
  input  logic [LANES-1:0] sym_bad_disp,
  input  logic             comma_ok,
  output logic [1:0]       sync_status,
  output logic             realign_req
);

  localparam int NW = $clog2(LANES + 1);

  logic [NW-1:0] nbad;
  logic          any_bad;
  logic          trip;
  logic          decay_evt;
  logic          count_en;
  sync_state_e   state_q;

  rxsync_errsum #(.LANES(LANES)) u_errsum (
    .bad_table (sym_bad_table),
    .bad_disp  (sym_bad_disp),
    .nbad      (nbad),
    .any_bad   (any_bad)
  );

  // R8/R9: no counting while lost or while tracking is off
  assign count_en = track_en && (state_q != SY_LOST);

  rxsync_leaky #(.LANES(LANES), .INCR(INCR), .THRESH(THRESH)) u_leaky (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (rx_reset),
    .count_en  (count_en),
    .nbad      (nbad),
    .trip      (trip),
    .decay_evt (decay_evt)
  );

  rxsync_fsm #(.WAIT_CYCLES(WAIT_CYCLES)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_reset (rx_reset),
    .en       (track_en),
    .any_bad  (any_bad),
    .trip     (trip),
    .comma_ok (comma_ok),
    .state_q  (state_q)
  );

  assign sync_status = state_q;
  assign realign_req = (state_q == SY_LOST);

  AST_REALIGN_ONLY_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    realign_req |-> sync_status == 2'b10); // R1

endmodule

// File: tb/rx_sync_tracker_test.sv
module rx_sync_tracker_test;

  localparam int CLK_P = 10;
  localparam int LANES = 2;
  localparam int NVEC  = 57;

  // {rx_reset, track_en, comma_ok, bad_table[1:0], bad_disp[1:0], expected status[1:0]}
  // status codes (R1): 00 acquired, 01 resync, 10 lost
  localparam logic [8:0] VEC [NVEC] = '{
    9'b1_1_0_00_00_10,  // 0  R2 sync reset
    9'b0_1_0_01_00_10,  // 1  R8 error ignored while lost
    9'b0_1_1_01_00_10,  // 2  R8 comma with error stays lost
    9'b0_1_1_00_00_00,  // 3  R8 clean comma acquires
    9'b0_1_0_01_00_01,  // 4  R3 table error -> resync, count 1
    9'b0_1_0_00_00_01,  // 5  R6
    9'b0_1_0_00_00_01,  // 6  R6
    9'b0_1_0_00_00_01,  // 7  R6
    9'b0_1_0_00_00_00,  // 8  R6 fourth clean -> acquired; R7 leak to 0
    9'b0_1_0_00_10_01,  // 9  R3 disparity error lane1, count 1
    9'b0_1_0_10_00_01,  // 10 R6 restart, count 2
    9'b0_1_0_01_01_01,  // 11 R3 both flags one lane count once -> 3
    9'b0_1_0_00_00_01,  // 12
    9'b0_1_0_00_00_01,  // 13
    9'b0_1_0_00_00_01,  // 14
    9'b0_1_0_00_00_00,  // 15 R7 leak 3 -> 2
    9'b0_1_0_01_00_01,  // 16 R7 count 3, not lost thanks to leak
    9'b0_1_0_01_10_10,  // 17 R4 two lanes add 2 -> 5, R5 lost
    9'b0_1_1_00_00_00,  // 18 reacquire
    9'b0_1_0_01_00_01,  // 19 spacing 4: count 1
    9'b0_1_0_00_00_01,  // 20
    9'b0_1_0_00_00_01,  // 21
    9'b0_1_0_00_00_01,  // 22
    9'b0_1_0_01_00_01,  // 23 count 2
    9'b0_1_0_00_00_01,  // 24
    9'b0_1_0_00_00_01,  // 25
    9'b0_1_0_00_00_01,  // 26
    9'b0_1_0_01_00_01,  // 27 count 3
    9'b0_1_0_00_00_01,  // 28
    9'b0_1_0_00_00_01,  // 29
    9'b0_1_0_00_00_01,  // 30
    9'b0_1_0_01_00_10,  // 31 R5 count reaches 4 from resync
    9'b0_1_1_00_00_00,  // 32
    9'b0_1_0_01_00_01,  // 33 spacing 5
    9'b0_1_0_00_00_01,  // 34
    9'b0_1_0_00_00_01,  // 35
    9'b0_1_0_00_00_01,  // 36
    9'b0_1_0_00_00_00,  // 37 R6 R7
    9'b0_1_0_01_00_01,  // 38
    9'b0_1_0_00_00_01,  // 39
    9'b0_1_0_00_00_01,  // 40
    9'b0_1_0_00_00_01,  // 41
    9'b0_1_0_00_00_00,  // 42
    9'b0_1_0_01_00_01,  // 43 count 1
    9'b0_0_0_01_00_00,  // 44 R9 disabled -> acquired, count cleared
    9'b0_1_0_00_00_00,  // 45
    9'b0_1_0_01_00_01,  // 46 R9 count restarts at 1
    9'b0_1_0_01_00_01,  // 47 2
    9'b0_1_0_01_00_01,  // 48 3
    9'b0_1_0_01_00_10,  // 49 4 -> lost
    9'b0_1_1_00_00_00,  // 50
    9'b1_1_1_00_00_10,  // 51 R2 sync reset beats comma
    9'b0_1_1_00_00_00,  // 52
    9'b1_1_0_00_00_10,  // 53 R2
    9'b0_0_0_11_11_00,  // 54 R9 disable leaves lost, errors ignored
    9'b0_0_0_11_00_00,  // 55 R9
    9'b0_1_0_00_00_00   // 56
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_reset = 1'b0;
  logic track_en = 1'b1;
  logic comma_ok = 1'b0;
  logic [LANES-1:0] bad_t = '0;
  logic [LANES-1:0] bad_d = '0;
  logic [1:0] st;
  logic rq;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P / 2) clk = ~clk;

  rx_sync_tracker #(.LANES(LANES)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_reset      (rx_reset),
    .track_en      (track_en),
    .sym_bad_table (bad_t),
    .sym_bad_disp  (bad_d),
    .comma_ok      (comma_ok),
    .sync_status   (st),
    .realign_req   (rq)
  );

  task automatic check(input string tag, input logic [1:0] exp_s);
    n_chk++;
    if (st !== exp_s || rq !== (exp_s == 2'b10)) begin
      n_bad++;
      $display("FAIL %s: status=%b realign=%b expected status=%b realign=%b",
               tag, st, rq, exp_s, (exp_s == 2'b10));
    end
  endtask

  initial begin
    #(CLK_P * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #2;
    check("R2 reset state", 2'b10);
    rst_n = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      {rx_reset, track_en, comma_ok, bad_t, bad_d} = VEC[i][8:2];
      @(posedge clk);
      #2;
      check($sformatf("R1 vector %0d", i), VEC[i][1:0]);
    end
    // R2: asynchronous reset from resync takes effect without a clock edge
    {rx_reset, track_en, comma_ok, bad_t, bad_d} = 7'b0_1_0_01_00;
    @(posedge clk);
    #2;
    check("R3 error before async reset", 2'b01);
    bad_t = '0;
    rst_n = 1'b0;
    #1;
    check("R2 async reset", 2'b10);
    #2;
    rst_n = 1'b1;
    comma_ok = 1'b1;
    @(posedge clk);
    #2;
    check("R8 reacquire after async reset", 2'b00);
    comma_ok = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule